// File: doc/BRIEF.md
# Rotating-Priority Vectored Interrupt Controller

This block gathers 64 interrupt request lines and presents them to a processor through a small 32-bit register bus with per-byte write strobes. Every source owns one control byte. That byte sets whether the source is enabled, how it triggers and which of eight destinations it drives. A source can be active-high level, rising edge, falling edge or both edges. The destinations are the normal interrupt line, the fast interrupt line and six auxiliary lines.

Edge-mode sources capture their events in sticky pending flags. Software clears a flag by writing 1 to it. Level-mode sources show their masked input live. The processor reads a vector register to learn which enabled source routed to the normal interrupt line should be served next. The search is either fixed, where the lowest number wins, or rotating, where it resumes just above the source reported by the last vector read.

Register offsets: vector at 0x00, normal-line priority control at 0x20, fast-line priority control at 0x24, control bytes at 0x40 + source number, and status words at 0x80 (sources 0..31) and 0x84 (sources 32..63). Reads return data on the cycle after the read strobe.

Top module: `vic_rotating`

## Requirements
- R1: After reset every control byte, both status words and the interrupt outputs are 0, and the vector register reads 63.
- R2: A write updates only the control bytes whose byte strobe is set. Source n sits in word 0x40 + 4*(n/4), lane n%4, and reads back unchanged.
- R3: Control bit 3 is the enable. A disabled level source shows 0 in its status bit, drives no output and is never reported by the vector register.
- R4: With control bits 6:5 = 00 the source is active-high level. Its status bit equals input AND enable in the same cycle, and writes to its status bit have no effect.
- R5: Bit 5 latches rising edges and bit 6 latches falling edges; both set latches either edge. An edge is seen when the current input differs from the value registered on the previous clock. The flag is visible one clock later and stays set after the input returns.
- R6: Writing 1 to an edge source's status bit, with its byte strobe set, clears its flag. Writing 0, or writing with the strobe clear, has no effect. An edge arriving in the same cycle as the clear leaves the flag set.
- R7: The vector register returns in bits 5:0 the selected source, or 63 when no enabled normal-line source is pending. A real source 63 also shows status word 0x84 bit 31 = 1.
- R8: With rotation off (bit 6 of 0x20 = 0), the lowest-numbered enabled pending normal-line source is reported.
- R9: With rotation on, the search starts at pointer + 1, wrapping past 63. Each vector read that reports a real source loads the pointer (0x20 bits 5:0) with that source. Both priority control registers store bits 6:0 and read them back.
- R10: Control bits 2:0 route an enabled pending source: 0 to irq_o, 1 to fiq_o, and k = 2..7 to aux_o[k-2]. Each output is the OR of its routed sources.
- R11: Source n appears in status word 0x80 + 4*(n/32) at bit n%32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_addr | input | 8 | Byte address of the 32-bit word |
| bus_wdata | input | 32 | Write data |
| bus_be | input | 4 | Byte write strobes |
| bus_rdata | output | 32 | Read data, valid the cycle after bus_rd |
| src_in | input | 64 | Interrupt request inputs |
| irq_o | output | 1 | Normal interrupt line |
| fiq_o | output | 1 | Fast interrupt line |
| aux_o | output | 6 | Auxiliary interrupt lines |

## Verification
A software clear and a fresh edge on the same source can land on the same clock. This is provoked by raising a rising-edge source in the very cycle that a write-1 to its status bit is presented. The expected result is that the flag survives, read back from status word 0x84. A second overlap is a rotating vector read while several sources are pending. Each read is judged against the next source above the previously reported one, including the wrap from 63 back to the lowest pending source.

// File: rtl/vic_pkg.sv
package vic_pkg;
    localparam int NSRC       = 64;
    localparam int IDX_W      = $clog2(NSRC);
    localparam int NDEST      = 8;
    localparam int AW         = 8;
    localparam int DW         = 32;
    localparam int LANES      = DW / 8;
    localparam int CTRL_WORDS = NSRC / LANES;
    localparam int CW_W       = $clog2(CTRL_WORDS);
    localparam int STAT_WORDS = NSRC / DW;
    localparam int SW_W       = (STAT_WORDS > 1) ? $clog2(STAT_WORDS) : 1;

    localparam logic [AW-1:0] OFS_INDEX    = 8'h00;
    localparam logic [AW-1:0] OFS_IRQ_PRIO = 8'h20;
    localparam logic [AW-1:0] OFS_FIQ_PRIO = 8'h24;
    localparam logic [AW-1:0] OFS_CTRL     = 8'h40;
    localparam logic [AW-1:0] OFS_STAT     = 8'h80;

    typedef struct packed {
        logic       spare7;
        logic       fall;
        logic       rise;
        logic       spare4;
        logic       en;
        logic [2:0] dest;
    } src_ctrl_t;

    typedef struct packed {
        logic             rot;
        logic [IDX_W-1:0] ptr;
    } prio_t;

    typedef struct packed {
        logic             hit;
        logic [IDX_W-1:0] idx;
    } pick_t;

    function automatic pick_t first_set(input logic [NSRC-1:0] v);
        pick_t r;
        r.hit = 1'b0;
        r.idx = '0;
        for (int i = NSRC - 1; i >= 0; i--) begin
            if (v[i]) begin
                r.hit = 1'b1;
                r.idx = IDX_W'(i);
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/vic_src_cfg.sv
module vic_src_cfg
    import vic_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            wr,
    input  logic [AW-1:0]   addr,
    input  logic [DW-1:0]   wdata,
    input  logic [LANES-1:0] be,
    output src_ctrl_t       ctrl [NSRC],
    output prio_t           fiq_prio
);
    for (genvar n = 0; n < NSRC; n++) begin : g_src
        localparam int LANE = n % LANES;
        localparam logic [AW-3:0] WADDR = (AW-2)'((int'(OFS_CTRL) >> 2) + n / LANES);
        always_ff @(posedge clk) begin
            if (rst)
                ctrl[n] <= '0;
            else if (wr && addr[AW-1:2] == WADDR && addr[1:0] == 2'b00 && be[LANE])
                ctrl[n] <= src_ctrl_t'(wdata[LANE*8 +: 8]);
        end
    end

    always_ff @(posedge clk) begin
        if (rst)
            fiq_prio <= '0;
        else if (wr && addr == OFS_FIQ_PRIO && be[0])
            fiq_prio <= prio_t'(wdata[$bits(prio_t)-1:0]);
    end
endmodule

// File: rtl/vic_pending.sv
module vic_pending
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  src,
    input  src_ctrl_t        ctrl [NSRC],
    input  logic             wr,
    input  logic [AW-1:0]    addr,
    input  logic [DW-1:0]    wdata,
    input  logic [LANES-1:0] be,
    output logic [NSRC-1:0]  status,
    output logic [NSRC-1:0]  elig
);
    logic [NSRC-1:0] prev_q, latch_q, set_v, clr_v, edge_v, en_v;

    for (genvar n = 0; n < NSRC; n++) begin : g_bit
        localparam int WRD = n / DW;
        localparam int BIT = n % DW;
        localparam logic [AW-1:0] WADDR = AW'(int'(OFS_STAT) + 4 * WRD);
        always_comb begin
            en_v[n]   = ctrl[n].en;
            edge_v[n] = ctrl[n].rise | ctrl[n].fall;
            set_v[n]  = (ctrl[n].rise &  src[n] & ~prev_q[n]) |
                        (ctrl[n].fall & ~src[n] &  prev_q[n]);
            clr_v[n]  = wr && addr == WADDR && be[BIT/8] && wdata[BIT];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prev_q  <= '0;
            latch_q <= '0;
        end else begin
            prev_q  <= src;
            latch_q <= edge_v & (set_v | (latch_q & ~clr_v));
        end
    end

    assign status = (edge_v & latch_q) | (~edge_v & src & en_v);
    assign elig   = status & en_v;

    // R5: every detected edge shows up in the latch one clock later
    a_r5_edge_captured: assert property (@(posedge clk) disable iff (rst)
        (|set_v) |=> ((latch_q & $past(set_v)) == $past(set_v)));

    // R6: a latch only drops after a clear write or a switch to level mode
    a_r6_drop_needs_clear: assert property (@(posedge clk) disable iff (rst)
        (($past(latch_q) & ~latch_q & ~$past(clr_v | ~edge_v)) == '0));
endmodule

// File: rtl/vic_prio_pick.sv
module vic_prio_pick
    import vic_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NSRC-1:0]  req,
    input  logic             rd_idx,
    input  logic             prio_we,
    input  prio_t            prio_wdata,
    output logic [IDX_W-1:0] idx,
    output logic             any,
    output prio_t            prio_q
);
    logic [IDX_W-1:0]  off;
    logic [2*NSRC-1:0] dbl;
    logic [NSRC-1:0]   rv;
    pick_t             pk;

    always_comb begin
        off = prio_q.rot ? prio_q.ptr + IDX_W'(1) : '0;
        dbl = {req, req} >> off;
        rv  = dbl[NSRC-1:0];
        pk  = first_set(rv);
        any = pk.hit;
        idx = pk.hit ? pk.idx + off : IDX_W'(NSRC - 1);
    end

    always_ff @(posedge clk) begin
        if (rst)
            prio_q <= '0;
        else if (prio_we)
            prio_q <= prio_wdata;
        else if (rd_idx && any && prio_q.rot)
            prio_q.ptr <= idx;
    end

    // R7: idle vector value
    a_r7_idle_is_top: assert property (@(posedge clk) disable iff (rst)
        !any |-> (idx == IDX_W'(NSRC - 1)));

    // R7: a reported source is really requesting
    a_r7_winner_requests: assert property (@(posedge clk) disable iff (rst)
        any |-> req[idx]);

    // R8: fixed order never skips a lower requester
    a_r8_lowest_when_fixed: assert property (@(posedge clk) disable iff (rst)
        (any && !prio_q.rot) |->
        ((req & ((NSRC'(1) << idx) - NSRC'(1))) == '0));
endmodule

// File: rtl/vic_rotating.sv
module vic_rotating
    import vic_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic        bus_rd,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    input  logic [3:0]  bus_be,
    output logic [31:0] bus_rdata,
    input  logic [63:0] src_in,
    output logic        irq_o,
    output logic        fiq_o,
    output logic [5:0]  aux_o
);
    src_ctrl_t              ctrl [NSRC];
    prio_t                  fiq_prio, irq_prio;
    logic [NSRC-1:0]        status, elig;
    logic [NDEST-1:0][NSRC-1:0] route;
    logic [NSRC*8-1:0]      ctrl_flat;
    logic [IDX_W-1:0]       idx;
    logic                   any;
    logic                   rd_idx, prio_we;

    vic_src_cfg u_cfg (
        .clk(clk), .rst(rst), .wr(bus_wr), .addr(bus_addr),
        .wdata(bus_wdata), .be(bus_be), .ctrl(ctrl), .fiq_prio(fiq_prio)
    );

    vic_pending u_pend (
        .clk(clk), .rst(rst), .src(src_in), .ctrl(ctrl), .wr(bus_wr),
        .addr(bus_addr), .wdata(bus_wdata), .be(bus_be),
        .status(status), .elig(elig)
    );

    assign rd_idx  = bus_rd && bus_addr == OFS_INDEX;
    assign prio_we = bus_wr && bus_addr == OFS_IRQ_PRIO && bus_be[0];

    vic_prio_pick u_pick (
        .clk(clk), .rst(rst), .req(route[0]), .rd_idx(rd_idx),
        .prio_we(prio_we), .prio_wdata(prio_t'(bus_wdata[$bits(prio_t)-1:0])),
        .idx(idx), .any(any), .prio_q(irq_prio)
    );

    for (genvar n = 0; n < NSRC; n++) begin : g_flat
        assign ctrl_flat[n*8 +: 8] = ctrl[n];
        for (genvar d = 0; d < NDEST; d++) begin : g_dest
            assign route[d][n] = elig[n] && ctrl[n].dest == 3'(d);
        end
    end

    assign irq_o = |route[0];
    assign fiq_o = |route[1];
    for (genvar d = 2; d < NDEST; d++) begin : g_aux
        assign aux_o[d-2] = |route[d];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata <= '0;
        end else if (bus_rd) begin
            if (bus_addr == OFS_INDEX)
                bus_rdata <= DW'(idx);
            else if (bus_addr == OFS_IRQ_PRIO)
                bus_rdata <= DW'(irq_prio);
            else if (bus_addr == OFS_FIQ_PRIO)
                bus_rdata <= DW'(fiq_prio);
            else if (bus_addr >= OFS_CTRL && bus_addr < OFS_STAT)
                bus_rdata <= ctrl_flat[{bus_addr[2 +: CW_W], 5'd0} +: DW];
            else if (bus_addr >= OFS_STAT && bus_addr < AW'(int'(OFS_STAT) + 4 * STAT_WORDS))
                bus_rdata <= status[{bus_addr[2 +: SW_W], 5'd0} +: DW];
            else
                bus_rdata <= '0;
        end
    end

    // R7: an idle vector read returns 63 on the following cycle
    a_r7_idle_read: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && bus_addr == OFS_INDEX && !(|route[0])) |=> (bus_rdata[5:0] == 6'd63));

    // R10: fast line never rises without an enabled pending source
    a_r10_fiq_has_source: assert property (@(posedge clk) disable iff (rst)
        fiq_o |-> (|elig));
endmodule

// File: tb/vic_rotating_test.sv
module vic_rotating_test;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [3:0]  bus_be = '0;
    logic [31:0] bus_rdata;
    logic [63:0] src_in = '0;
    logic        irq_o, fiq_o;
    logic [5:0]  aux_o;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        chk_next = 1'b0;
    logic [31:0] mon_e;
    string       mon_t;

    vic_rotating uut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_be(bus_be),
        .bus_rdata(bus_rdata), .src_in(src_in), .irq_o(irq_o),
        .fiq_o(fiq_o), .aux_o(aux_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic finish_up();
        if (!done) begin
            done = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // monitor: compares each read result against the scoreboard
    always @(posedge clk) chk_next <= bus_rd;
    always @(negedge clk) begin
        if (chk_next) begin
            if (exp_q.size() == 0) begin
                n_chk++;
                n_fail++;
                $display("FAIL scoreboard actual=%h expected=<none>", bus_rdata);
            end else begin
                mon_e = exp_q.pop_front();
                mon_t = tag_q.pop_front();
                check(mon_t, bus_rdata, mon_e);
            end
        end
    end

    task automatic step();
        @(negedge clk);
    endtask

    task automatic wr_word(logic [7:0] a, logic [31:0] d, logic [3:0] be);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d; bus_be = be;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd_expect(logic [7:0] a, logic [31:0] e, string tag);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_src(int n, logic v);
        @(negedge clk);
        src_in[n] = v;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_up();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd_expect(8'h40, 32'h0, "R1 ctrl word 0x40");
        rd_expect(8'h7C, 32'h0, "R1 ctrl word 0x7C");
        rd_expect(8'h80, 32'h0, "R1 status 0x80");
        rd_expect(8'h84, 32'h0, "R1 status 0x84");
        rd_expect(8'h00, 32'd63, "R1 R7 idle vector");
        step();
        check("R1 outputs", {24'h0, irq_o, fiq_o, aux_o}, 32'h0);

        // R2 byte-lane writes
        wr_word(8'h44, 32'h0000_0800, 4'b0010);
        rd_expect(8'h44, 32'h0000_0800, "R2 lane1 write");
        wr_word(8'h44, 32'hFFFF_FF09, 4'b0001);
        rd_expect(8'h44, 32'h0000_0809, "R2 lane0 write keeps lane1");

        // R4 level source 5 routed to irq
        set_src(5, 1'b1);
        step();
        check("R4 level irq_o", 32'(irq_o), 32'h1);
        rd_expect(8'h80, 32'h0000_0020, "R4 R11 level status");
        rd_expect(8'h00, 32'd5, "R7 vector level source");
        wr_word(8'h80, 32'h0000_0020, 4'b1111);
        rd_expect(8'h80, 32'h0000_0020, "R4 write ignored");
        set_src(5, 1'b0);
        step();
        check("R4 level released", 32'(irq_o), 32'h0);
        rd_expect(8'h80, 32'h0, "R4 status follows input");

        // R10 / R3 source 4 on fiq
        set_src(4, 1'b1);
        step();
        check("R10 fiq_o", {30'h0, fiq_o, irq_o}, 32'h2);
        rd_expect(8'h80, 32'h0000_0010, "R10 status src4");
        wr_word(8'h44, 32'h0000_0001, 4'b0001);
        check("R3 disabled fiq_o", 32'(fiq_o), 32'h0);
        rd_expect(8'h80, 32'h0, "R3 disabled status");
        rd_expect(8'h00, 32'd63, "R3 disabled not vectored");
        set_src(4, 1'b0);

        // R10 aux routing, source 10 in word 0x48 lane 2
        wr_word(8'h48, 32'h000D_0000, 4'b0100);
        set_src(10, 1'b1);
        step();
        check("R10 aux dest5", 32'(aux_o), 32'h08);
        wr_word(8'h48, 32'h000F_0000, 4'b0100);
        check("R10 aux dest7", 32'(aux_o), 32'h20);
        set_src(10, 1'b0);
        step();
        check("R10 aux released", 32'(aux_o), 32'h0);

        // R5 edges: 40 rising, 41 falling, 42 both
        wr_word(8'h68, 32'h0068_4828, 4'b0111);
        set_src(41, 1'b1);
        step();
        rd_expect(8'h84, 32'h0, "R5 falling ignores rise");
        set_src(40, 1'b1);
        set_src(40, 1'b0);
        step();
        rd_expect(8'h84, 32'h0000_0100, "R5 R11 rise held");
        check("R5 irq_o from latch", 32'(irq_o), 32'h1);
        set_src(41, 1'b0);
        step();
        rd_expect(8'h84, 32'h0000_0300, "R5 falling latched");
        set_src(42, 1'b1);
        step();
        rd_expect(8'h84, 32'h0000_0700, "R5 both rise");
        wr_word(8'h84, 32'h0000_0400, 4'b0010);
        rd_expect(8'h84, 32'h0000_0300, "R6 clear src42");
        set_src(42, 1'b0);
        step();
        rd_expect(8'h84, 32'h0000_0700, "R5 both fall");

        // R6 clear rules
        wr_word(8'h84, 32'h0, 4'b1111);
        rd_expect(8'h84, 32'h0000_0700, "R6 write 0 no effect");
        wr_word(8'h84, 32'h0000_0100, 4'b0001);
        rd_expect(8'h84, 32'h0000_0700, "R6 strobe off no effect");
        wr_word(8'h84, 32'h0000_0100, 4'b0010);
        rd_expect(8'h84, 32'h0000_0600, "R6 clear src40");
        rd_expect(8'h80, 32'h0, "R11 low word empty");

        // R6 clear and new edge in the same cycle
        @(negedge clk);
        src_in[40] = 1'b1;
        bus_wr = 1'b1; bus_addr = 8'h84; bus_wdata = 32'h0000_0100; bus_be = 4'b0010;
        @(negedge clk);
        bus_wr = 1'b0; bus_be = '0;
        rd_expect(8'h84, 32'h0000_0700, "R6 edge beats clear");
        set_src(40, 1'b0);

        // R8 fixed priority
        rd_expect(8'h00, 32'd40, "R8 lowest wins");
        wr_word(8'h84, 32'h0000_0100, 4'b0010);
        rd_expect(8'h00, 32'd41, "R8 next lowest");

        // R7 real source 63
        wr_word(8'h7C, 32'h0800_0000, 4'b1000);
        set_src(63, 1'b1);
        step();
        rd_expect(8'h84, 32'h8000_0600, "R7 bit31 marks source 63");
        rd_expect(8'h00, 32'd41, "R8 fixed with 63 pending");

        // R9 rotation
        wr_word(8'h20, 32'h0000_0040, 4'b0001);
        rd_expect(8'h20, 32'h0000_0040, "R9 prio readback");
        rd_expect(8'h00, 32'd41, "R9 rotate first");
        rd_expect(8'h00, 32'd42, "R9 rotate second");
        rd_expect(8'h00, 32'd63, "R9 rotate third");
        rd_expect(8'h00, 32'd41, "R9 rotate wrap");
        rd_expect(8'h20, 32'h0000_0069, "R9 pointer loaded");
        wr_word(8'h20, 32'h0000_0072, 4'b0001);
        rd_expect(8'h00, 32'd63, "R9 start above written pointer");
        rd_expect(8'h00, 32'd41, "R9 wrap after 63");
        wr_word(8'h24, 32'h0000_0055, 4'b0001);
        rd_expect(8'h24, 32'h0000_0055, "R9 fast prio readback");

        // R7 idle vs real 63
        wr_word(8'h84, 32'h0000_0600, 4'b0010);
        set_src(63, 1'b0);
        step();
        rd_expect(8'h00, 32'd63, "R7 idle vector");
        rd_expect(8'h84, 32'h0, "R7 idle bit31 clear");
        check("R7 irq_o idle", 32'(irq_o), 32'h0);
        step();
        step();
        finish_up();
    end
endmodule